// File: doc/BRIEF.md
# Error Pin Controller with Release Key

This block owns an active-low fault pin that tells an external monitor something has gone wrong. A single-cycle error event pulls the pin low, and a minimum low time then starts. That time is counted down from a preload value that is sampled whenever the counter is (re)started. Software controls the pin through a 4-bit key register. One key value asks for the pin to be released. Another holds the pin low for a safety test. Every other value means "no request".

Release is deliberately strict. The pin goes back high only when the release key is held at a moment when the low-time counter is at zero. The release key can be written while the counter is still running, or it can be written after the counter has expired. After a release, the key register clears itself. Leaving the forcing mode, or writing a neutral key while the pin is low, never releases the pin. Such a write restarts the low time and cancels any pending release request.

A small register port lets software write the key and read back the key, the pin level and the remaining low time. Reads are combinational.

Top module: `epc_error_pin`

## Requirements
- R1: After reset the pin output is high, the key register reads 0x0 and the counter reads 0.
- R2: An error event pulls the pin low at the next clock edge and loads the counter with the preload value at that same edge.
- R3: While the pin is low and the counter is not reloaded, the counter decrements by one per cycle down to 0 and then holds. The pin stays low as long as the counter is nonzero, even if the release key is held. A preload of 0 gives an immediately expired low time.
- R4: With key 0x5 held and the pin low, the pin returns high at the clock edge following the first cycle in which the counter reads 0.
- R5: If key 0x5 is written after the counter has already reached 0, the pin returns high at the edge following the write.
- R6: At the edge that releases the pin, the key register returns to 0x0 without any write.
- R7: Key 0xA forces the pin low from the edge after it is stored. While 0xA is held, the counter is kept at the preload value.
- R8: Writing 0xA and then 0x0 does not release the pin. The 0x0 write restarts the counter at the preload value, and the pin stays low after the counter expires.
- R9: Writing 0x0 while the pin is low and 0x5 is pending cancels the request and reloads the counter. The pin stays low until 0x5 is written again.
- R10: Key values other than 0x5 and 0xA (for example 0x3) act as 0x0. They neither force nor release the pin, and they read back as written.
- R11: An error event while the counter is running with 0x5 pending reloads the counter and clears the key to 0x0. The pin then stays low until 0x5 is written again.
- R12: Register map, selected by the read address:
  - Address 0 returns the key in bits 3:0.
  - Address 1 returns the pin level in bit 0 (1 = high).
  - Address 2 returns the counter value.
  - Address 3 returns 0.

  Writes take effect only at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 1 | Single-cycle error event |
| preload | input | CNT_W | Minimum low time, sampled at each counter restart |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 4 | Key value to write |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| err_pin_n | output | 1 | Active-low error pin |

## Verification
The assertions assume that `err_evt` is a single-cycle pulse and that `preload` is steady from the reload edge onward. They also assume that key writes and error events are not issued in the same cycle, because simultaneity is resolved in favour of the write without further guarantees. The directed stimulus drives every input on the falling clock edge. It separates each event from every key write by at least one full cycle, and it changes the preload only while the pin is high.

// File: rtl/epc_pkg.sv
package epc_pkg;

  localparam int KEY_W = 4;

  localparam logic [KEY_W-1:0] KEY_IDLE    = 4'h0;
  localparam logic [KEY_W-1:0] KEY_RELEASE = 4'h5;
  localparam logic [KEY_W-1:0] KEY_FORCE   = 4'hA;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_RELEASE = 2'd1,
    MODE_FORCE   = 2'd2
  } key_mode_e;

  // Every value that is neither release nor force behaves as idle.
  function automatic key_mode_e key_mode(input logic [KEY_W-1:0] k);
    case (k)
      KEY_RELEASE: return MODE_RELEASE;
      KEY_FORCE:   return MODE_FORCE;
      default:     return MODE_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/epc_key_reg.sv
module epc_key_reg
  import epc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             err_evt,
  input  logic             release_evt,
  output logic [KEY_W-1:0] key_q,
  output key_mode_e        mode
);

  logic cancel_req;

  assign mode       = key_mode(key_q);
  assign cancel_req = err_evt && (mode == MODE_RELEASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           key_q <= KEY_IDLE;
    else if (key_wr)      key_q <= wr_key;
    else if (release_evt) key_q <= KEY_IDLE;
    else if (cancel_req)  key_q <= KEY_IDLE;
  end

  assert_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> key_q == KEY_IDLE);

  assert_key_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !release_evt && !err_evt) |=> $stable(key_q));

endmodule

// File: rtl/epc_lowtime_cnt.sv
module epc_lowtime_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             run,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] cnt_next(
    input logic [CNT_W-1:0] cur,
    input logic             ld,
    input logic             go,
    input logic [CNT_W-1:0] pre
  );
    if (ld)                          return pre;
    else if (go && cur != '0)        return cur - ONE;
    else                             return cur;
  endfunction

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, reload, run, preload);
  end

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(preload));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && run && !cnt_zero) |=> cnt_q == $past(cnt_q) - ONE);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cnt_zero) |=> cnt_zero);

endmodule

// File: rtl/epc_pin_ctrl.sv
module epc_pin_ctrl
  import epc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      err_evt,
  input  key_mode_e mode,
  input  key_mode_e wr_mode,
  input  logic      key_wr,
  input  logic      cnt_zero,
  output logic      pin_low,
  output logic      reload_evt,
  output logic      release_evt
);

  logic drive_low;
  logic neutral_wr;

  assign drive_low   = err_evt || (mode == MODE_FORCE);
  assign neutral_wr  = pin_low && key_wr && (wr_mode == MODE_NORMAL);
  assign reload_evt  = drive_low || neutral_wr;
  assign release_evt = pin_low && cnt_zero && (mode == MODE_RELEASE)
                       && !err_evt && !key_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pin_low <= 1'b0;
    else if (drive_low)   pin_low <= 1'b1;
    else if (release_evt) pin_low <= 1'b0;
  end

  assert_event_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> pin_low);

  assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FORCE) |=> pin_low);

  assert_release_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !pin_low);

  assert_rise_only_key5_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_low) |-> ($past(mode) == MODE_RELEASE) && $past(cnt_zero));

endmodule

// File: rtl/epc_error_pin.sv
module epc_error_pin
  import epc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  input  logic [CNT_W-1:0]  preload,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_pin_n
);

  localparam logic [ADDR_W-1:0] ADDR_KEY    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = ADDR_W'(2);

  logic             key_wr;
  key_mode_e        wr_mode;
  logic [KEY_W-1:0] key_q;
  key_mode_e        mode;
  logic             pin_low;
  logic             reload_evt;
  logic             release_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign key_wr  = wr_en && (wr_addr == ADDR_KEY);
  assign wr_mode = key_mode(wr_data);

  epc_key_reg i_key (
    .clk, .rst_n, .key_wr, .wr_key(wr_data), .err_evt,
    .release_evt, .key_q, .mode
  );

  epc_pin_ctrl i_pin (
    .clk, .rst_n, .err_evt, .mode, .wr_mode, .key_wr, .cnt_zero,
    .pin_low, .reload_evt, .release_evt
  );

  epc_lowtime_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk, .rst_n, .reload(reload_evt), .run(pin_low), .preload,
    .cnt_q, .cnt_zero
  );

  assign err_pin_n = !pin_low;

  always_comb begin
    case (rd_addr)
      ADDR_KEY:    rd_data = DATA_W'(key_q);
      ADDR_STATUS: rd_data = DATA_W'(err_pin_n);
      ADDR_COUNT:  rd_data = DATA_W'(cnt_q);
      default:     rd_data = '0;
    endcase
  end

  assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_low && !cnt_zero) |=> pin_low);

  assert_no_rise_without_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_low && mode != MODE_RELEASE) |=> pin_low);

endmodule

// File: tb/test_epc_error_pin.sv
module test_epc_error_pin;

  localparam int CNT_W = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              err_evt = 1'b0;
  logic [CNT_W-1:0]  preload = 16'd5;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [3:0]        wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              err_pin_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  epc_error_pin #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_epc_error_pin (
    .clk, .rst_n, .err_evt, .preload, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .err_pin_n
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // Expected pin level (1 = high), key and counter, read through the port.
  task automatic expect_state(input string tag, input logic pin, input logic [3:0] key,
                              input int cnt);
    logic [31:0] v;
    check({tag, " pin"}, 32'(err_pin_n), 32'(pin));
    rd(2'd1, v); check({tag, " status"}, v, 32'(pin));
    rd(2'd0, v); check({tag, " key"}, v, 32'(key));
    rd(2'd2, v); check({tag, " count"}, v, 32'(cnt));
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic write_key(input logic [3:0] k, input logic [1:0] a = 2'd0);
    wr_en = 1'b1; wr_addr = a; wr_data = k;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_addr = '0;
  endtask

  task automatic pulse_err();
    err_evt = 1'b1;
    @(negedge clk);
    err_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    expect_state("R1 reset", 1'b1, 4'h0, 0);
    rd(2'd3, v); check("R12 unmapped read", v, 32'h0);
    write_key(4'hA, 2'd3);
    idle(1);
    expect_state("R12 write elsewhere ignored", 1'b1, 4'h0, 0);
  endtask

  task automatic t_countdown_release();
    pulse_err();
    expect_state("R2 event low", 1'b0, 4'h0, 5);
    write_key(4'h5);
    expect_state("R3 first step", 1'b0, 4'h5, 4);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      expect_state("R3 countdown", 1'b0, 4'h5, 4 - i);
    end
    @(negedge clk);
    expect_state("R4 R6 release and autoclear", 1'b1, 4'h0, 0);
  endtask

  task automatic t_late_key();
    pulse_err();
    idle(7);
    expect_state("R3 expired stays low", 1'b0, 4'h0, 0);
    write_key(4'h5);
    expect_state("R5 key stored", 1'b0, 4'h5, 0);
    @(negedge clk);
    expect_state("R5 late release", 1'b1, 4'h0, 0);
  endtask

  task automatic t_force();
    write_key(4'hA);
    expect_state("R7 key stored", 1'b1, 4'hA, 0);
    @(negedge clk);
    expect_state("R7 forced low", 1'b0, 4'hA, 5);
    idle(4);
    expect_state("R7 counter held", 1'b0, 4'hA, 5);
    write_key(4'h0);
    expect_state("R8 exit force reload", 1'b0, 4'h0, 5);
    idle(10);
    expect_state("R8 no release", 1'b0, 4'h0, 0);
    write_key(4'h5);
    @(negedge clk);
    expect_state("R8 recover by key", 1'b1, 4'h0, 0);
  endtask

  task automatic t_cancel_by_write();
    pulse_err();
    write_key(4'h5);
    idle(2);
    expect_state("R9 pending", 1'b0, 4'h5, 2);
    write_key(4'h0);
    expect_state("R9 cancel reload", 1'b0, 4'h0, 5);
    idle(8);
    expect_state("R9 still low", 1'b0, 4'h0, 0);
    write_key(4'h5);
    @(negedge clk);
    expect_state("R9 released", 1'b1, 4'h0, 0);
  endtask

  task automatic t_other_key();
    write_key(4'h3);
    idle(2);
    expect_state("R10 no force", 1'b1, 4'h3, 0);
    pulse_err();
    idle(8);
    expect_state("R10 no release", 1'b0, 4'h3, 0);
    write_key(4'h3);
    expect_state("R10 acts as idle reload", 1'b0, 4'h3, 5);
    write_key(4'h5);
    idle(5);
    expect_state("R10 recover", 1'b1, 4'h0, 0);
  endtask

  task automatic t_event_cancel();
    pulse_err();
    write_key(4'h5);
    idle(2);
    pulse_err();
    expect_state("R11 event reload cancel", 1'b0, 4'h0, 5);
    idle(8);
    expect_state("R11 still low", 1'b0, 4'h0, 0);
    write_key(4'h5);
    @(negedge clk);
    expect_state("R11 released", 1'b1, 4'h0, 0);
  endtask

  task automatic t_zero_preload();
    preload = '0;
    pulse_err();
    expect_state("R3 zero preload", 1'b0, 4'h0, 0);
    write_key(4'h5);
    @(negedge clk);
    expect_state("R5 zero preload release", 1'b1, 4'h0, 0);
    preload = 16'd5;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_countdown_release();
    t_late_key();
    t_force();
    t_cancel_by_write();
    t_other_key();
    t_event_cancel();
    t_zero_preload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule